// File: doc/BRIEF.md
# Bridge Forwarding Address Decoder

This block decides, on each address phase that reaches a bridge port, whether the bridge should claim that transaction and carry it across to the other bus. It has one set of address windows: an I/O window, a non-prefetchable memory window and a prefetchable memory window. On the primary side a transaction is claimed when its address falls inside a window that matches its command class. On the secondary side the rule is inverted, so the transaction is claimed only when its address falls outside every window of its class. When an ISA-compatibility control is set, it removes holes from the low 64 KB of the I/O window. The same holes are added to upstream forwarding.

The window bounds come from configuration state that is kept elsewhere. I/O bounds give address bits 31:12. The base is taken with its low 12 bits at 000h and the limit with its low 12 bits at FFFh. Memory bounds give address bits 31:20. The base is taken with its low bits at zero and the limit with its low bits at FFFFFh. All comparisons are inclusive. The decision is registered and appears one clock after the request strobe, together with a flag that marks a claim made through the prefetchable window.

Top module: `fwd_addr_decoder`

## Requirements
- R1: While rst_ni is low, and on the first clock after it is released, fwd_valid_o, fwd_claim_o and fwd_pref_o are 0.
- R2: fwd_valid_o equals req_valid_i delayed by one clock. fwd_claim_o and fwd_pref_o give the decision for the request sampled on that same edge.
- R3: A primary-side (req_from_sec_i=0) I/O command (req_cmd_i 4'h2 or 4'h3) is claimed exactly when io_base_i <= req_addr_i[31:12] <= io_limit_i.
- R4: A primary-side memory command (req_cmd_i 4'h6, 4'h7, 4'hC, 4'hE or 4'hF) is claimed exactly when req_addr_i[31:20] lies inclusively within [mem_base_i, mem_limit_i] or within [pf_base_i, pf_limit_i].
- R5: fwd_pref_o is 1 only for a primary-side memory claim whose address lies in the prefetchable window. It is 0 for I/O, for non-prefetchable hits and for every secondary-side request.
- R6: A secondary-side (req_from_sec_i=1) I/O or memory command is claimed exactly when its address lies outside every window of its own class.
- R7: A window whose base is greater than its limit contains no address.
- R8: With isa_en_i=1, an I/O address with bits 31:16 all zero and bits 9:8 not 00 is treated as outside the I/O window. It is never claimed downstream and is always claimed upstream. With isa_en_i=0, or at addresses of 64 KB and above, the I/O window is used unchanged.
- R9: Commands other than the I/O and memory codes above (for example 4'h0, 4'hA, 4'hB) are never claimed from either side.
- R10: I/O commands are compared only against the I/O window, and memory commands only against the two memory windows.
- R11: When req_valid_i is 0, fwd_claim_o and fwd_pref_o are 0 on the next clock, whatever the address and command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Address phase present |
| req_addr_i | input | 32 | Transaction address |
| req_cmd_i | input | 4 | Bus command code |
| req_from_sec_i | input | 1 | 0: seen on primary side, 1: seen on secondary side |
| io_base_i | input | 20 | I/O window base, address bits 31:12 |
| io_limit_i | input | 20 | I/O window limit, address bits 31:12 |
| mem_base_i | input | 12 | Memory window base, address bits 31:20 |
| mem_limit_i | input | 12 | Memory window limit, address bits 31:20 |
| pf_base_i | input | 12 | Prefetchable window base, address bits 31:20 |
| pf_limit_i | input | 12 | Prefetchable window limit, address bits 31:20 |
| isa_en_i | input | 1 | ISA aliasing enable |
| fwd_valid_o | output | 1 | Decision valid |
| fwd_claim_o | output | 1 | Claim and forward the transaction |
| fwd_pref_o | output | 1 | Claim was made through the prefetchable window |

## Verification
The bench places addresses on both inclusive edges of each window and one step beyond each edge. A design that is off by one at the limit, or that fills the low bits of the limit with zeros, claims or drops the first or last 4 KB or 1 MB. The same addresses are repeated from the secondary side, where a design missing the inversion claims the wrong half of the address space. The ISA holes are probed with bits 9:8 set to 00, 01 and 11, above and below 64 KB and in both directions: a wrong hole test either drops legal ISA addresses or leaks aliased ones across. Crossed command classes, unclaimable command codes and empty windows with a base above the limit show up as claims where none belong.

// File: rtl/fwd_dec_pkg.sv
package fwd_dec_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_IO   = 2'd1,
    CLS_MEM  = 2'd2
  } cmd_cls_e;

  function automatic cmd_cls_e classify(input logic [3:0] cmd);
    case (cmd)
      4'h2, 4'h3:                      return CLS_IO;
      4'h6, 4'h7, 4'hC, 4'hE, 4'hF:    return CLS_MEM;
      default:                         return CLS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fwd_dec_window.sv
module fwd_dec_window #(
  parameter int W = 12
) (
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic nonempty;

  // base above limit marks the window empty
  assign nonempty = (base_i <= limit_i);
  assign hit_o    = nonempty && (addr_i >= base_i) && (addr_i <= limit_i);

endmodule

// File: rtl/fwd_dec_isa_hole.sv
module fwd_dec_isa_hole #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic              hole_o
);
  localparam int LOW64K_W = 16;

  logic below_64k;

  assign below_64k = (addr_i[ADDR_W-1:LOW64K_W] == '0);
  // upper 768 bytes of each 1 KB block alias to ISA space
  assign hole_o    = en_i && below_64k && (addr_i[9:8] != 2'b00);

endmodule

// File: rtl/fwd_addr_decoder.sv
module fwd_addr_decoder
  import fwd_dec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IO_GRAN  = 12,
  parameter int MEM_GRAN = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [3:0]               req_cmd_i,
  input  logic                     req_from_sec_i,
  input  logic [ADDR_W-IO_GRAN-1:0]  io_base_i,
  input  logic [ADDR_W-IO_GRAN-1:0]  io_limit_i,
  input  logic [ADDR_W-MEM_GRAN-1:0] mem_base_i,
  input  logic [ADDR_W-MEM_GRAN-1:0] mem_limit_i,
  input  logic [ADDR_W-MEM_GRAN-1:0] pf_base_i,
  input  logic [ADDR_W-MEM_GRAN-1:0] pf_limit_i,
  input  logic                     isa_en_i,
  output logic                     fwd_valid_o,
  output logic                     fwd_claim_o,
  output logic                     fwd_pref_o
);
  localparam int IO_W    = ADDR_W - IO_GRAN;
  localparam int MEM_W   = ADDR_W - MEM_GRAN;
  localparam int N_MEMWIN = 2;  // 0: non-prefetchable, 1: prefetchable

  cmd_cls_e cls;
  logic     io_hit, isa_hole, io_in, mem_in;
  logic [N_MEMWIN-1:0] mwin_hit;
  logic [MEM_W-1:0]    mwin_base  [N_MEMWIN];
  logic [MEM_W-1:0]    mwin_limit [N_MEMWIN];
  logic     claim_c, pref_c;
  logic     unused_addr_bits;

  assign unused_addr_bits = ^req_addr_i;
  assign cls = classify(req_cmd_i);

  fwd_dec_window #(.W(IO_W)) u_io_win (
    .addr_i  (req_addr_i[ADDR_W-1:IO_GRAN]),
    .base_i  (io_base_i),
    .limit_i (io_limit_i),
    .hit_o   (io_hit)
  );

  fwd_dec_isa_hole #(.ADDR_W(ADDR_W)) u_isa (
    .addr_i (req_addr_i),
    .en_i   (isa_en_i),
    .hole_o (isa_hole)
  );

  assign mwin_base[0]  = mem_base_i;
  assign mwin_limit[0] = mem_limit_i;
  assign mwin_base[1]  = pf_base_i;
  assign mwin_limit[1] = pf_limit_i;

  for (genvar g = 0; g < N_MEMWIN; g++) begin : g_memwin
    fwd_dec_window #(.W(MEM_W)) u_win (
      .addr_i  (req_addr_i[ADDR_W-1:MEM_GRAN]),
      .base_i  (mwin_base[g]),
      .limit_i (mwin_limit[g]),
      .hit_o   (mwin_hit[g])
    );
  end

  // ISA holes are cut out of the I/O window for both directions
  assign io_in  = io_hit && !isa_hole;
  assign mem_in = |mwin_hit;

  always_comb begin
    claim_c = 1'b0;
    pref_c  = 1'b0;
    unique case (cls)
      CLS_IO:  claim_c = req_from_sec_i ? !io_in : io_in;
      CLS_MEM: begin
        claim_c = req_from_sec_i ? !mem_in : mem_in;
        pref_c  = !req_from_sec_i && mwin_hit[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_o <= 1'b0;
      fwd_claim_o <= 1'b0;
      fwd_pref_o  <= 1'b0;
    end else begin
      fwd_valid_o <= req_valid_i;
      fwd_claim_o <= req_valid_i && claim_c;
      fwd_pref_o  <= req_valid_i && pref_c;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> fwd_valid_o);
  a_r11_idle_no_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!fwd_valid_o && !fwd_claim_o && !fwd_pref_o));
  a_r5_pref_needs_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_pref_o |-> (fwd_claim_o && fwd_valid_o));
  a_r5_no_pref_upstream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_from_sec_i) |=> !fwd_pref_o);
  a_r9_other_cmd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cls == CLS_NONE) |=> !fwd_claim_o);
  a_r8_hole_not_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_from_sec_i && cls == CLS_IO && isa_hole) |=> !fwd_claim_o);

endmodule

// File: tb/fwd_addr_decoder_tb.sv
module fwd_addr_decoder_tb;

  typedef struct packed {
    logic        sec;
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic        isa;
    logic        claim;
    logic        pref;
  } vec_t;

  localparam int NV = 26;
  // windows: I/O 0x1000-0x2FFF, mem 0x1000_0000-0x1FFF_FFFF, pf 0x8000_0000-0x8FFF_FFFF
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h2, 32'h0000_1000, 1'b0, 1'b1, 1'b0},  // R3 base edge
    '{1'b0, 4'h3, 32'h0000_2FFF, 1'b0, 1'b1, 1'b0},  // R3 limit edge
    '{1'b0, 4'h2, 32'h0000_3000, 1'b0, 1'b0, 1'b0},  // R3 above
    '{1'b0, 4'h2, 32'h0000_0FFF, 1'b0, 1'b0, 1'b0},  // R3 below
    '{1'b0, 4'h6, 32'h1000_0000, 1'b0, 1'b1, 1'b0},  // R4 base
    '{1'b0, 4'h7, 32'h1FFF_FFFC, 1'b0, 1'b1, 1'b0},  // R4 limit
    '{1'b0, 4'h6, 32'h2000_0000, 1'b0, 1'b0, 1'b0},  // R4 above
    '{1'b0, 4'hC, 32'h8000_0000, 1'b0, 1'b1, 1'b1},  // R5 pf base
    '{1'b0, 4'hE, 32'h8FFF_FFFF, 1'b0, 1'b1, 1'b1},  // R5 pf limit
    '{1'b0, 4'hF, 32'h9000_0000, 1'b0, 1'b0, 1'b0},  // R5 pf above
    '{1'b1, 4'h6, 32'h2000_0000, 1'b0, 1'b1, 1'b0},  // R6 up outside
    '{1'b1, 4'h6, 32'h1000_0000, 1'b0, 1'b0, 1'b0},  // R6 up inside mem
    '{1'b1, 4'h7, 32'h8000_0004, 1'b0, 1'b0, 1'b0},  // R6 up inside pf
    '{1'b1, 4'h2, 32'h0000_3000, 1'b0, 1'b1, 1'b0},  // R6 up io outside
    '{1'b1, 4'h3, 32'h0000_1000, 1'b0, 1'b0, 1'b0},  // R6 up io inside
    '{1'b0, 4'h2, 32'h1000_0000, 1'b0, 1'b0, 1'b0},  // R10 io cmd in mem window
    '{1'b0, 4'h6, 32'h0000_1000, 1'b0, 1'b0, 1'b0},  // R10 mem cmd in io window
    '{1'b0, 4'hA, 32'h1000_0000, 1'b0, 1'b0, 1'b0},  // R9 config read
    '{1'b1, 4'hB, 32'h2000_0000, 1'b0, 1'b0, 1'b0},  // R9 config write up
    '{1'b0, 4'h0, 32'h8000_0000, 1'b0, 1'b0, 1'b0},  // R9 int ack
    '{1'b0, 4'h2, 32'h0000_1100, 1'b1, 1'b0, 1'b0},  // R8 hole 01
    '{1'b0, 4'h2, 32'h0000_1000, 1'b1, 1'b1, 1'b0},  // R8 bits 00
    '{1'b0, 4'h2, 32'h0000_13FF, 1'b1, 1'b0, 1'b0},  // R8 hole 11
    '{1'b1, 4'h3, 32'h0000_1200, 1'b1, 1'b1, 1'b0},  // R8 hole goes up
    '{1'b1, 4'h3, 32'h0000_10FC, 1'b1, 1'b0, 1'b0},  // R8 non-hole stays
    '{1'b0, 4'h2, 32'h0000_1100, 1'b0, 1'b1, 1'b0}   // R8 isa off
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic        req_sec = 1'b0;
  logic [19:0] io_base = 20'h00001, io_limit = 20'h00002;
  logic [11:0] mem_base = 12'h100, mem_limit = 12'h1FF;
  logic [11:0] pf_base = 12'h800, pf_limit = 12'h8FF;
  logic        isa_en = 1'b0;
  logic        fwd_valid, fwd_claim, fwd_pref;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fwd_addr_decoder u_dut (
    .clk_i (clk), .rst_ni (rst_ni),
    .req_valid_i (req_valid), .req_addr_i (req_addr), .req_cmd_i (req_cmd),
    .req_from_sec_i (req_sec),
    .io_base_i (io_base), .io_limit_i (io_limit),
    .mem_base_i (mem_base), .mem_limit_i (mem_limit),
    .pf_base_i (pf_base), .pf_limit_i (pf_limit),
    .isa_en_i (isa_en),
    .fwd_valid_o (fwd_valid), .fwd_claim_o (fwd_claim), .fwd_pref_o (fwd_pref)
  );

  task automatic check(input string req, input logic v, input logic c, input logic p);
    n_chk++;
    if (fwd_valid !== v || fwd_claim !== c || fwd_pref !== p) begin
      n_fail++;
      $display("FAIL %s: got v/c/p=%b%b%b expected %b%b%b", req,
               fwd_valid, fwd_claim, fwd_pref, v, c, p);
    end
  endtask

  task automatic apply(input logic s, input logic [3:0] cmd, input logic [31:0] a,
                       input logic isa, input logic c, input logic p, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_sec = s; req_cmd = cmd; req_addr = a; isa_en = isa;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, 1'b1, c, p);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    #1;
    check("R1", 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_cmd = 4'h6; req_addr = 32'h1000_0000;
    check("R1", 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    check("R1", 1'b0, 1'b0, 1'b0);

    // R2..R10 vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].sec, VEC[i].cmd, VEC[i].addr, VEC[i].isa,
            VEC[i].claim, VEC[i].pref, $sformatf("R2 vec %0d", i));
    end

    // R11 idle cycle carrying a claimable request
    @(negedge clk);
    req_valid = 1'b0; req_sec = 1'b0; req_cmd = 4'hC; req_addr = 32'h8000_0000;
    @(negedge clk);
    check("R11", 1'b0, 1'b0, 1'b0);

    // R2 back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_sec = 1'b0; req_cmd = 4'h6; req_addr = 32'h1000_0000; isa_en = 1'b0;
    @(negedge clk);
    req_cmd = 4'h6; req_addr = 32'h2000_0000;
    check("R2", 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", 1'b1, 1'b0, 1'b0);

    // R8 no holes at 64 KB and above
    io_base = 20'h00010; io_limit = 20'h00010;
    apply(1'b0, 4'h2, 32'h0001_0100, 1'b1, 1'b1, 1'b0, "R8 above 64K down");
    apply(1'b1, 4'h2, 32'h0001_0100, 1'b1, 1'b0, 1'b0, "R8 above 64K up");

    // R7 empty windows
    io_base = 20'h00003; io_limit = 20'h00002;
    mem_base = 12'h200; mem_limit = 12'h100;
    pf_base = 12'h900; pf_limit = 12'h800;
    apply(1'b0, 4'h2, 32'h0000_2800, 1'b0, 1'b0, 1'b0, "R7 io empty down");
    apply(1'b1, 4'h2, 32'h0000_2800, 1'b0, 1'b1, 1'b0, "R7 io empty up");
    apply(1'b0, 4'h6, 32'h1800_0000, 1'b0, 1'b0, 1'b0, "R7 mem empty down");
    apply(1'b0, 4'hE, 32'h8800_0000, 1'b0, 1'b0, 1'b0, "R7 pf empty down");
    apply(1'b1, 4'h7, 32'h1800_0000, 1'b0, 1'b1, 1'b0, "R7 mem empty up");

    // R3 single-page window, both edges
    io_base = 20'h00005; io_limit = 20'h00005;
    apply(1'b0, 4'h3, 32'h0000_5000, 1'b0, 1'b1, 1'b0, "R3 page base");
    apply(1'b0, 4'h3, 32'h0000_5FFF, 1'b0, 1'b1, 1'b0, "R3 page limit");
    apply(1'b0, 4'h3, 32'h0000_6000, 1'b0, 1'b0, 1'b0, "R3 page beyond");

    // R5 overlap: pref only via pf window
    mem_base = 12'h400; mem_limit = 12'h4FF; pf_base = 12'h4F0; pf_limit = 12'h4FF;
    apply(1'b0, 4'h6, 32'h4F00_0000, 1'b0, 1'b1, 1'b1, "R5 overlap pf");
    apply(1'b0, 4'h6, 32'h4E00_0000, 1'b0, 1'b1, 1'b0, "R5 mem only");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule